// File: doc/BRIEF.md
# Serial Register Port with Burst Access

This block is a slave serial port through which a host reaches a bank of 8-bit registers. The host lowers the chip select and clocks in a command byte on the serial clock. The command picks a register and a direction, and it can ask for burst access. One data byte follows, or for a burst a run of data bytes follows. The port has no register storage of its own. It drives one-cycle read and write strobes with an address toward an external register file. It also drives a flag that marks burst accesses, so the register file can leave its latched status bits alone on a burst read.

The chip select, serial clock and data input are sampled by a fast system clock through synchronizer stages, so the port is independent of any line-side clock. The serial clock must therefore be slow compared with the system clock: at least four system cycles per serial clock phase. The data output has a separate enable and is intended for a three-state pad. The enable is off during writes and whenever the chip select is high, so the data output can share a wire with the data input.

Top module: `serial_reg_port`

## Requirements
- R1: The command byte arrives least significant bit first. Bit 0 is the direction (1 = read, 0 = write), bits 4..1 are the register address (bit 1 is the address LSB), bits 6..5 are reserved, and bit 7 requests burst access.
- R2: Input bits are taken on rising serial clock edges. Read data leaves least significant bit first: each bit changes after a falling edge and holds until the next falling edge. The first bit follows the first falling edge after the command byte.
- R3: A non-burst write produces exactly one write strobe, carrying the command's address and the eight data bits that follow the command. Any later bytes in the same transaction cause no strobe.
- R4: A non-burst read produces exactly one read strobe, issued when the command byte completes, and the register value is shifted out in the next byte. The output enable is high only during the read data phase. It stays low during the command byte, during every write, and after the single read byte.
- R5: A high chip select drops the output enable at once and aborts the transaction. A partially shifted byte at that moment produces no strobe and changes no register.
- R6: A command whose reserved bits are not both zero is ignored for the whole transaction: no strobe, and no output drive.
- R7: Burst access starts only if bit 7 is set and the address is 0. With bit 7 set and any other address, the transaction behaves as a non-burst access.
- R8: During a burst, each completed byte accesses the next address, starting from 0. After the last used address (NUM_REGS-1) the address wraps to 0, and the walk continues until the chip select rises. A burst read fetches the next register at the end of each byte.
- R9: The burst flag is high with every strobe of a burst transaction and low with every strobe of a non-burst transaction.
- R10: Addresses at or above NUM_REGS are unused. A write there produces no strobe. A read there produces no strobe and shifts out 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial read data |
| sdo_oe | output | 1 | Output enable for the serial data pad |
| reg_addr | output | 4 | Register address for the current strobe |
| reg_wr_stb | output | 1 | One-cycle register write strobe |
| reg_wdata | output | 8 | Write data, valid with the write strobe |
| reg_rd_stb | output | 1 | One-cycle register read strobe |
| reg_rdata | input | 8 | Register file read data for reg_addr, combinational |
| reg_burst | output | 1 | Marks a strobe as belonging to a burst |

## Verification
Serial clock edges reach the control logic two system cycles after the pin changes. A strobe is therefore visible three cycles after a rising serial clock edge, and a new read data bit appears three cycles after a falling edge. The enable follows the raw chip select with no delay. Each host bit lasts sixteen system cycles. The bench samples the data output eight cycles after the falling edge and again just before the next falling edge, so the first sample and the hold check both land well after the output has settled. Strobes are logged as they occur and compared against a list built from the command after the chip select rises and twelve idle cycles have passed, which is long after the last strobe is due.

// File: rtl/srp_pkg.sv
package srp_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned ADDR_W = 4;
    localparam int unsigned BIT_CNT_W = $clog2(BYTE_W);

    typedef struct packed {
        logic              burst;
        logic [1:0]        rsvd;
        logic [ADDR_W-1:0] addr;
        logic              rd;
    } cmd_t;

    typedef enum logic [1:0] {
        PH_CMD  = 2'd0,
        PH_WR   = 2'd1,
        PH_RD   = 2'd2,
        PH_IDLE = 2'd3
    } phase_t;

    function automatic logic cmd_ok(cmd_t c);
        return c.rsvd == 2'b00;
    endfunction

    function automatic logic cmd_burst(cmd_t c);
        return c.burst && (c.addr == '0);
    endfunction

    function automatic logic addr_used(logic [ADDR_W-1:0] a, int unsigned n);
        return 32'(a) < n;
    endfunction

    function automatic logic [ADDR_W-1:0] addr_next(logic [ADDR_W-1:0] a, int unsigned n);
        if (32'(a) + 32'd1 >= n) return '0;
        return a + 1'b1;
    endfunction

endpackage

// File: rtl/srp_sync.sv
module srp_sync #(
    parameter int unsigned W       = 1,
    parameter int unsigned STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    generate
        if (STAGES <= 1) begin : g_single
            logic [W-1:0] stage_q;
            always_ff @(posedge clk) begin
                if (rst) stage_q <= RST_VAL;
                else     stage_q <= d;
            end
            assign q = stage_q;
        end else begin : g_chain
            logic [STAGES-1:0][W-1:0] pipe_q;
            always_ff @(posedge clk) begin
                if (rst) pipe_q <= {STAGES{RST_VAL}};
                else     pipe_q <= {pipe_q[STAGES-2:0], d};
            end
            assign q = pipe_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/srp_ctrl.sv
module srp_ctrl
    import srp_pkg::*;
#(
    parameter int unsigned NUM_REGS = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_act,
    input  logic              sclk_s,
    input  logic              sdi_s,
    output logic [ADDR_W-1:0] addr_o,
    output logic              wr_stb_o,
    output logic              rd_stb_o,
    output logic              burst_o,
    output logic [BYTE_W-1:0] wdata_o,
    output logic              ld_o,
    output logic              ld_zero_o,
    output logic              drive_o,
    output logic              fall_o
);

    logic                 sclk_q;
    logic                 rise;
    phase_t               phase;
    logic [BIT_CNT_W-1:0] bitcnt;
    logic [BYTE_W-2:0]    in_sr;
    logic [BYTE_W-1:0]    byte_nxt;
    cmd_t                 cmd_nxt;
    logic [ADDR_W-1:0]    cur_addr;
    logic [ADDR_W-1:0]    inc_addr;
    logic                 burst_q;
    logic                 last_bit;

    assign rise     = sclk_s & ~sclk_q;
    assign fall_o   = ~sclk_s & sclk_q & cs_act;
    assign byte_nxt = {sdi_s, in_sr};
    assign cmd_nxt  = cmd_t'(byte_nxt);
    assign inc_addr = addr_next(cur_addr, NUM_REGS);
    assign last_bit = (bitcnt == BIT_CNT_W'(BYTE_W - 1));
    assign drive_o  = (phase == PH_RD);

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q    <= 1'b0;
            phase     <= PH_CMD;
            bitcnt    <= '0;
            in_sr     <= '0;
            cur_addr  <= '0;
            burst_q   <= 1'b0;
            addr_o    <= '0;
            wdata_o   <= '0;
            wr_stb_o  <= 1'b0;
            rd_stb_o  <= 1'b0;
            burst_o   <= 1'b0;
            ld_o      <= 1'b0;
            ld_zero_o <= 1'b0;
        end else begin
            sclk_q   <= sclk_s;
            wr_stb_o <= 1'b0;
            rd_stb_o <= 1'b0;
            ld_o     <= 1'b0;
            if (!cs_act) begin
                phase   <= PH_CMD;
                bitcnt  <= '0;
                burst_q <= 1'b0;
                burst_o <= 1'b0;
            end else if (rise) begin
                in_sr  <= byte_nxt[BYTE_W-1:1];
                bitcnt <= bitcnt + 1'b1;
                if (last_bit) begin
                    unique case (phase)
                        PH_CMD: begin
                            if (!cmd_ok(cmd_nxt)) begin
                                phase <= PH_IDLE;
                            end else begin
                                burst_q  <= cmd_burst(cmd_nxt);
                                burst_o  <= cmd_burst(cmd_nxt);
                                cur_addr <= cmd_nxt.addr;
                                addr_o   <= cmd_nxt.addr;
                                if (cmd_nxt.rd) begin
                                    phase     <= PH_RD;
                                    ld_o      <= 1'b1;
                                    rd_stb_o  <= addr_used(cmd_nxt.addr, NUM_REGS);
                                    ld_zero_o <= !addr_used(cmd_nxt.addr, NUM_REGS);
                                end else begin
                                    phase <= PH_WR;
                                end
                            end
                        end
                        PH_WR: begin
                            addr_o   <= cur_addr;
                            wdata_o  <= byte_nxt;
                            burst_o  <= burst_q;
                            wr_stb_o <= addr_used(cur_addr, NUM_REGS);
                            if (burst_q) cur_addr <= inc_addr;
                            else         phase    <= PH_IDLE;
                        end
                        PH_RD: begin
                            if (burst_q) begin
                                cur_addr  <= inc_addr;
                                addr_o    <= inc_addr;
                                burst_o   <= 1'b1;
                                ld_o      <= 1'b1;
                                rd_stb_o  <= addr_used(inc_addr, NUM_REGS);
                                ld_zero_o <= !addr_used(inc_addr, NUM_REGS);
                            end else begin
                                phase <= PH_IDLE;
                            end
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    AST_STB_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(wr_stb_o && rd_stb_o)); // R4
    AST_WR_USED: assert property (@(posedge clk) disable iff (rst)
        wr_stb_o |-> (32'(addr_o) < NUM_REGS)); // R10
    AST_RD_USED: assert property (@(posedge clk) disable iff (rst)
        rd_stb_o |-> (32'(addr_o) < NUM_REGS)); // R10
    AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (rst)
        !cs_act |=> (!wr_stb_o && !rd_stb_o && !ld_o)); // R5
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE) |=> (!wr_stb_o && !rd_stb_o)); // R6
    AST_NO_WR_IN_RD: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_RD) |=> !wr_stb_o); // R3

endmodule

// File: rtl/srp_tx.sv
module srp_tx
    import srp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_act,
    input  logic              drive_en,
    input  logic              fall,
    input  logic              ld,
    input  logic [BYTE_W-1:0] ld_data,
    output logic              sdo_o,
    output logic              oe_o
);

    logic [BYTE_W-1:0] out_sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_sr <= '0;
            sdo_o  <= 1'b0;
            oe_o   <= 1'b0;
        end else begin
            if (ld) begin
                out_sr <= ld_data;
            end else if (fall && drive_en) begin
                sdo_o  <= out_sr[0];
                out_sr <= {1'b0, out_sr[BYTE_W-1:1]};
            end
            if (!cs_act || !drive_en) oe_o <= 1'b0;
            else if (fall)            oe_o <= 1'b1;
        end
    end

    AST_OE_CS: assert property (@(posedge clk) disable iff (rst)
        !cs_act |=> !oe_o); // R5
    AST_OE_RD_ONLY: assert property (@(posedge clk) disable iff (rst)
        !drive_en |=> !oe_o); // R4
    AST_SDO_HOLD: assert property (@(posedge clk) disable iff (rst)
        (oe_o && !fall && !$past(fall)) |=> $stable(sdo_o)); // R2

endmodule

// File: rtl/serial_reg_port.sv
module serial_reg_port
    import srp_pkg::*;
#(
    parameter int unsigned NUM_REGS    = 11,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cs_n,
    input  logic        sclk,
    input  logic        sdi,
    output logic        sdo,
    output logic        sdo_oe,
    output logic [3:0]  reg_addr,
    output logic        reg_wr_stb,
    output logic [7:0]  reg_wdata,
    output logic        reg_rd_stb,
    input  logic [7:0]  reg_rdata,
    output logic        reg_burst
);

    localparam int unsigned PIN_W = 3;

    logic [PIN_W-1:0]  pins_s;
    logic              cs_act;
    logic              ld;
    logic              ld_zero;
    logic              drive;
    logic              fall;
    logic              oe_q;
    logic [BYTE_W-1:0] ld_data;

    srp_sync #(
        .W       (PIN_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b001)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({sdi, sclk, cs_n}),
        .q   (pins_s)
    );

    assign cs_act = ~pins_s[0];

    srp_ctrl #(
        .NUM_REGS (NUM_REGS)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cs_act    (cs_act),
        .sclk_s    (pins_s[1]),
        .sdi_s     (pins_s[2]),
        .addr_o    (reg_addr),
        .wr_stb_o  (reg_wr_stb),
        .rd_stb_o  (reg_rd_stb),
        .burst_o   (reg_burst),
        .wdata_o   (reg_wdata),
        .ld_o      (ld),
        .ld_zero_o (ld_zero),
        .drive_o   (drive),
        .fall_o    (fall)
    );

    assign ld_data = ld_zero ? '0 : reg_rdata;

    srp_tx u_tx (
        .clk      (clk),
        .rst      (rst),
        .cs_act   (cs_act),
        .drive_en (drive),
        .fall     (fall),
        .ld       (ld),
        .ld_data  (ld_data),
        .sdo_o    (sdo),
        .oe_o     (oe_q)
    );

    assign sdo_oe = oe_q & ~cs_n;

    AST_EN_FOLLOWS_CS: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sdo_oe); // R5
    AST_BURST_WITH_STB: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_stb && reg_burst) |=> !reg_wr_stb); // R9

endmodule

// File: tb/serial_reg_port_tb_top.sv
`timescale 1ns/1ps
module serial_reg_port_tb_top;

    localparam int NREG = 11;
    localparam int H    = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1;
    logic sclk = 1'b0;
    logic sdi = 1'b0;
    logic sdo, sdo_oe, reg_wr_stb, reg_rd_stb, reg_burst;
    logic [3:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;

    always #2 clk = ~clk;

    serial_reg_port #(.NUM_REGS(NREG), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .sdo(sdo), .sdo_oe(sdo_oe), .reg_addr(reg_addr),
        .reg_wr_stb(reg_wr_stb), .reg_wdata(reg_wdata),
        .reg_rd_stb(reg_rd_stb), .reg_rdata(reg_rdata), .reg_burst(reg_burst)
    );

    logic [7:0] model [16];
    logic [7:0] snap [16];
    assign reg_rdata = model[reg_addr];

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int ev_n = 0;
    logic       ev_k [64];
    logic [3:0] ev_a [64];
    logic [7:0] ev_d [64];
    logic       ev_b [64];

    logic [7:0] wd [16];
    logic [7:0] rx [16];
    int oe_d [16];
    int hold_d [16];
    int oe_cmd;

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (!rst) begin
            if (reg_wr_stb) begin
                model[reg_addr] = reg_wdata;
                if (ev_n < 64) begin
                    ev_k[ev_n] = 1'b0; ev_a[ev_n] = reg_addr;
                    ev_d[ev_n] = reg_wdata; ev_b[ev_n] = reg_burst;
                end
                ev_n = ev_n + 1;
            end
            if (reg_rd_stb) begin
                if (ev_n < 64) begin
                    ev_k[ev_n] = 1'b1; ev_a[ev_n] = reg_addr;
                    ev_d[ev_n] = 8'h00; ev_b[ev_n] = reg_burst;
                end
                ev_n = ev_n + 1;
            end
        end
        if (cyc > 190000) begin
            errors = errors + 1;
            $display("FAIL watchdog R1..: actual cycles=%0d expected < 190000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] mk(input bit b, input logic [1:0] rs, input logic [3:0] a, input bit rd);
        return {b, rs, a, rd};
    endfunction

    function automatic string tag_of(input logic [7:0] c);
        if (c[6:5] != 2'b00)                 return "R6";
        if (c[7] && c[4:1] == 4'd0)          return "R8";
        if (c[7])                            return "R7";
        if (int'(c[4:1]) >= NREG)            return "R10";
        if (c[0])                            return "R4";
        return "R3";
    endfunction

    task automatic host_bits(input logic [7:0] b, input int nb, output logic [7:0] r,
                             output int oe_n, output int hold_bad);
        r = 8'h00; oe_n = 0; hold_bad = 0;
        for (int i = 0; i < nb; i++) begin
            sdi = b[i];
            wclk(2);
            r[i] = sdo;
            oe_n = oe_n + int'(sdo_oe);
            sclk = 1'b1;
            wclk(H);
            if (sdo_oe && sdo !== r[i]) hold_bad = hold_bad + 1;
            sclk = 1'b0;
            wclk(H - 2);
        end
    endtask

    task automatic verify(input logic [7:0] c, input int nd);
        logic       ex_k [64];
        logic [3:0] ex_a [64];
        logic [7:0] ex_d [64];
        int  ex_n = 0;
        bit  ok   = (c[6:5] == 2'b00);
        bit  bst  = c[7] && (c[4:1] == 4'd0);
        bit  rd   = c[0];
        string t  = tag_of(c);
        chk(oe_cmd == 0, "R4", "enable during command byte", oe_cmd, 0);
        if (ok && rd) begin
            for (int j = 0; j < (bst ? nd + 1 : 1); j++) begin
                int aj = bst ? (j % NREG) : int'(c[4:1]);
                if (aj < NREG) begin
                    ex_k[ex_n] = 1'b1; ex_a[ex_n] = 4'(aj); ex_d[ex_n] = 8'h00; ex_n++;
                end
            end
        end else if (ok) begin
            for (int k = 0; k < (bst ? nd : 1); k++) begin
                int ak = bst ? (k % NREG) : int'(c[4:1]);
                if (ak < NREG) begin
                    ex_k[ex_n] = 1'b0; ex_a[ex_n] = 4'(ak); ex_d[ex_n] = wd[k]; ex_n++;
                end
            end
        end
        chk(ev_n == ex_n, t, "strobe count", ev_n, ex_n);
        for (int e = 0; e < ex_n && e < ev_n; e++) begin
            chk(ev_k[e] == ex_k[e] && ev_a[e] == ex_a[e] && ev_d[e] == ex_d[e], t,
                "strobe kind/addr/data (R1 decode)",
                int'({ev_k[e], ev_a[e], ev_d[e]}), int'({ex_k[e], ex_a[e], ex_d[e]}));
            chk(ev_b[e] == bst, "R9", "burst flag with strobe", int'(ev_b[e]), int'(bst));
        end
        for (int k = 0; k < nd; k++) begin
            bit act = ok && rd && (bst || k == 0);
            int ak = bst ? (k % NREG) : int'(c[4:1]);
            chk(oe_d[k] == (act ? 8 : 0), "R4", "enable samples in data byte", oe_d[k], act ? 8 : 0);
            if (act) begin
                logic [7:0] ev = (ak < NREG) ? snap[ak] : 8'h00;
                chk(rx[k] == ev, (ak < NREG) ? "R2" : "R10", "read byte", rx[k], ev);
                chk(hold_d[k] == 0, "R2", "data held until falling edge", hold_d[k], 0);
            end
        end
    endtask

    task automatic xfer(input logic [7:0] c, input int nd);
        logic [7:0] r;
        int o, hb;
        for (int i = 0; i < 16; i++) snap[i] = model[i];
        ev_n = 0;
        cs_n = 1'b0;
        wclk(H);
        host_bits(c, 8, r, o, hb);
        oe_cmd = o;
        for (int k = 0; k < nd; k++) host_bits(wd[k], 8, rx[k], oe_d[k], hold_d[k]);
        wclk(H);
        cs_n = 1'b1;
        wclk(12);
        verify(c, nd);
    endtask

    initial begin
        logic [7:0] r, c;
        int o, hb, nd;
        void'($urandom(32'h5EED_2024));
        for (int i = 0; i < 16; i++) model[i] = 8'($urandom);
        wclk(5);
        rst = 1'b0;
        wclk(4);
        chk(sdo_oe == 1'b0, "R4", "enable after reset", int'(sdo_oe), 0);
        chk(ev_n == 0, "R5", "no strobes after reset", ev_n, 0);

        // R3 / R4 single write then read back
        wd[0] = 8'h3C; wd[1] = 8'hC3;
        xfer(mk(0, 2'b00, 4'd3, 0), 2);
        xfer(mk(0, 2'b00, 4'd3, 1), 2);
        chk(rx[0] == 8'h3C, "R3", "written value read back", rx[0], 8'h3C);

        // R8 burst write wraps past the last used address, then burst read
        for (int k = 0; k < 14; k++) wd[k] = 8'($urandom);
        xfer(mk(1, 2'b00, 4'd0, 0), 14);
        xfer(mk(1, 2'b00, 4'd0, 1), 13);

        // R7 burst bit with nonzero address
        wd[0] = 8'h5A; wd[1] = 8'hA5;
        xfer(mk(1, 2'b00, 4'd5, 0), 2);
        xfer(mk(1, 2'b00, 4'd5, 1), 2);

        // R6 reserved bits set
        xfer(mk(0, 2'b01, 4'd2, 0), 1);
        xfer(mk(1, 2'b10, 4'd0, 1), 3);

        // R10 unused addresses
        xfer(mk(0, 2'b00, 4'd13, 0), 1);
        xfer(mk(0, 2'b00, 4'd15, 1), 1);
        xfer(mk(0, 2'b00, 4'd11, 1), 1);

        // R5 partial byte discarded at chip select rise
        for (int i = 0; i < 16; i++) snap[i] = model[i];
        ev_n = 0;
        cs_n = 1'b0; wclk(H);
        host_bits(mk(0, 2'b00, 4'd2, 0), 8, r, o, hb);
        host_bits(8'hFF, 5, r, o, hb);
        cs_n = 1'b1; wclk(12);
        chk(ev_n == 0, "R5", "strobes after partial byte", ev_n, 0);
        chk(model[2] == snap[2], "R5", "register after partial byte", model[2], snap[2]);
        ev_n = 0;
        cs_n = 1'b0; wclk(H);
        host_bits(mk(0, 2'b00, 4'd1, 1), 4, r, o, hb);
        cs_n = 1'b1; wclk(12);
        chk(ev_n == 0, "R5", "strobes after partial command", ev_n, 0);

        // R5 enable drops at once when chip select rises mid-read
        cs_n = 1'b0; wclk(H);
        host_bits(mk(0, 2'b00, 4'd0, 1), 8, r, o, hb);
        host_bits(8'h00, 3, r, o, hb);
        chk(sdo_oe == 1'b1, "R4", "enable during read data", int'(sdo_oe), 1);
        cs_n = 1'b1;
        #0.5;
        chk(sdo_oe == 1'b0, "R5", "enable right after chip select rise", int'(sdo_oe), 0);
        wclk(12);

        // constrained random mix
        for (int n = 0; n < 50; n++) begin
            c = 8'($urandom);
            if ($urandom % 8 != 0) c[6:5] = 2'b00;
            if ($urandom % 3 == 0) c[4:1] = 4'd0;
            nd = (c[7] && c[4:1] == 4'd0) ? 1 + int'($urandom % 14) : 1 + int'($urandom % 3);
            for (int k = 0; k < 16; k++) wd[k] = 8'($urandom);
            xfer(c, nd);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule